// File: doc/BRIEF.md
# Masked Multi-Field Alarm Comparator

This block watches four current-time fields (minute, hour, day of month, day of week), held as raw BCD, and compares each against a programmable alarm value. Each alarm value has its own disable bit. The comparison is true when at least one field is enabled and every enabled field equals its current-time field.

On the first cycle of such a match the block sets a sticky alarm flag. The flag stays set until software clears it with a one-cycle strobe. While the alarm interrupt enable is high, the interrupt output is a plain level copy of the flag.

A two-state tracker handles re-arming.
- **ST_WAIT** means no match is in progress. The transition **match_seen** (ST_WAIT to ST_HOLD) is taken when the comparison becomes true, and it is the only event that sets the flag.
- **ST_HOLD** means the current match has already been reported. The transition **match_gone** (ST_HOLD to ST_WAIT) is taken when the comparison turns false.

As a result, a match that continues after the flag is cleared does not set the flag again. Any hour-format conversion is up to the time source; the block compares raw codes on both sides.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, the outputs are low: `alarm_flag` = 0 and `alarm_irq` = 0. Every field is disabled, with its value 0.
- R2: A write (`wr_en` = 1) stores `wr_data` into the field picked by `wr_sel`. The codes are 0 = minute, 1 = hour, 2 = day, 3 = weekday. Bit 7 of `wr_data` is the disable bit (1 excludes the field) and bits 6:0 are the BCD value. The new value applies to the comparison from the next cycle.
- R3: `alarm_flag` rises on the clock edge that ends the first cycle in which all enabled fields equal the matching slices of `cur_time`. Field i occupies bits 7i+6 down to 7i.
- R4: A disabled field does not affect the comparison, whatever its stored value.
- R5: With all four fields disabled, `alarm_flag` never sets.
- R6: `alarm_flag` stays 1 until a cycle with `flag_clr` = 1. After that cycle it reads 0.
- R7: After a clear, a match that continues does not set the flag again. The comparison must first go false and then true again.
- R8: If `flag_clr` arrives in the same cycle as a new match, the set wins and the flag is 1 afterwards.
- R9: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and `irq_en` is 1. It falls in the same cycle as the flag, with no pulse mode.
- R10: The tracker takes match_seen (ST_WAIT to ST_HOLD) when the comparison is true. It takes match_gone (ST_HOLD to ST_WAIT) when the comparison is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 28 | Current BCD fields, minute in the low 7 bits, weekday in the high 7 bits |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 2 | Field select for the write |
| wr_data | input | 8 | Bit 7 is the disable bit, bits 6:0 are the BCD value |
| flag_clr | input | 1 | One-cycle clear strobe for the flag |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Level interrupt |

## Verification
The comparator is tried with the following patterns:
- A single enabled field stepping into and out of its value, which shows the rising-edge set apart from a level set.
- Mixed enable masks in which a disabled field holds a deliberately mismatching value, which shows masking apart from plain equality.
- All four fields enabled with exactly one field off by one, which catches a comparator that ignores a lane.
- The empty mask with the current time equal to the stored values, which separates "nothing enabled" from "everything matches".

Clear strobes are placed inside a continuing match, on the cycle of a fresh match, and after the match has ended. These separate the re-arm rule from the set/clear priority. A long pseudo-random walk over a small value alphabet then mixes writes, clears and enable toggles.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // Field lane order shared by the write decoder and the time bus
    localparam int unsigned LANE_MIN  = 0;
    localparam int unsigned LANE_HOUR = 1;
    localparam int unsigned LANE_DAY  = 2;
    localparam int unsigned LANE_WDAY = 3;

    // Match tracker states
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,   // no match in progress, flag may be set
        ST_HOLD = 1'b1    // match already reported
    } match_state_t;

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs #(
    parameter int unsigned NUM   = 4,
    parameter int unsigned VAL_W = 7,
    parameter int unsigned SEL_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [VAL_W:0]     wr_data,
    output logic [NUM*VAL_W-1:0] val_flat,
    output logic [NUM-1:0]     dis
);

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_lane
            logic [VAL_W-1:0] val_q;
            logic             dis_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                    dis_q <= 1'b1;
                end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                    val_q <= wr_data[VAL_W-1:0];
                    dis_q <= wr_data[VAL_W];
                end
            end

            assign val_flat[g*VAL_W +: VAL_W] = val_q;
            assign dis[g]                     = dis_q;
        end
    endgenerate

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
    parameter int unsigned NUM   = 4,
    parameter int unsigned VAL_W = 7
) (
    input  logic [NUM*VAL_W-1:0] cur_flat,
    input  logic [NUM*VAL_W-1:0] val_flat,
    input  logic [NUM-1:0]       dis,
    output logic                 match
);

    logic [NUM-1:0] lane_ok;

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_cmp
            always_comb begin
                lane_ok[g] = dis[g] ||
                    (cur_flat[g*VAL_W +: VAL_W] == val_flat[g*VAL_W +: VAL_W]);
            end
        end
    endgenerate

    always_comb begin
        match = (~&dis) && (&lane_ok);
    end

endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
    import alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         match,
    input  logic         flag_clr,
    output match_state_t state,
    output logic         flag
);

    match_state_t nxt;
    logic         set_evt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: match_seen and match_gone
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: if (match)  nxt = ST_HOLD;
            ST_HOLD: if (!match) nxt = ST_WAIT;
            default: nxt = ST_WAIT;
        endcase
    end

    // Output process: flag set on match_seen; set has priority over clear
    always_comb begin
        set_evt = (state == ST_WAIT) && match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
    import alarm_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 4,
    parameter int unsigned VAL_W      = 7,
    localparam int unsigned SEL_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
    localparam int unsigned BUS_W     = NUM_FIELDS * VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] cur_time,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [VAL_W:0]   wr_data,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             alarm_flag,
    output logic             alarm_irq
);

    logic [BUS_W-1:0]      fld_val;
    logic [NUM_FIELDS-1:0] fld_dis;
    logic                  cmp_match;
    match_state_t          fsm_state;

    alarm_regs #(
        .NUM   (NUM_FIELDS),
        .VAL_W (VAL_W),
        .SEL_W (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .val_flat (fld_val),
        .dis      (fld_dis)
    );

    alarm_cmp #(
        .NUM   (NUM_FIELDS),
        .VAL_W (VAL_W)
    ) u_cmp (
        .cur_flat (cur_time),
        .val_flat (fld_val),
        .dis      (fld_dis),
        .match    (cmp_match)
    );

    alarm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (cmp_match),
        .flag_clr (flag_clr),
        .state    (fsm_state),
        .flag     (alarm_flag)
    );

    always_comb begin
        alarm_irq = alarm_flag && irq_en;
    end

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
    import alarm_pkg::*;
#(
    parameter int unsigned NUM = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           flag_clr,
    input logic           irq_en,
    input logic           alarm_flag,
    input logic           alarm_irq,
    input logic           match,
    input match_state_t   state,
    input logic [NUM-1:0] dis
);

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && match) |=> alarm_flag); // R3

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (&dis) |-> !match); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(state == ST_WAIT && match)) |=> !alarm_flag); // R6

    AST_NO_RESET_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !alarm_flag) |=> !alarm_flag); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !alarm_irq); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag); // R9

    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !match) |=> (state == ST_WAIT)); // R10

endmodule

bind alarm_match_top alarm_match_chk #(.NUM(NUM_FIELDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq),
    .match      (cmp_match),
    .state      (fsm_state),
    .dis        (fld_dis)
);

// File: tb/alarm_match_top_bench.sv
`timescale 1ns/1ps
module alarm_match_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] cur_time = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        alarm_flag;
    logic        alarm_irq;

    always #10 clk = ~clk;   // 50 MHz

    alarm_match_top u_alarm_match_top (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq_en(irq_en),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    // Behavioural reference model
    int    m_val [4];
    bit    m_dis [4];
    bit    m_flag;
    bit    m_prev;
    int    vectors = 0;
    int    miscompares = 0;
    string phase = "R1";
    bit    done = 0;

    function automatic bit model_match();
        int enabled = 0;
        bit ok = 1;
        for (int i = 0; i < 4; i++) begin
            if (!m_dis[i]) begin
                enabled++;
                if (int'(cur_time[i*7 +: 7]) != m_val[i]) ok = 0;
            end
        end
        return (enabled > 0) && ok;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_dis[i] = 1; end
            m_flag = 0;
            m_prev = 0;
        end else begin
            bit mt;
            mt = model_match();
            if (mt && !m_prev) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_prev = mt;
            if (wr_en) begin
                m_val[wr_sel] = int'(wr_data[6:0]);
                m_dis[wr_sel] = wr_data[7];
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit e_irq;
            e_irq = m_flag && irq_en;
            vectors++;
            if (alarm_flag !== m_flag || alarm_irq !== e_irq) begin
                miscompares++;
                $display("FAIL %s: flag=%0b irq=%0b expected flag=%0b irq=%0b at %0t",
                         phase, alarm_flag, alarm_irq, m_flag, e_irq, $time);
            end
        end
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic set_time(logic [6:0] mi, logic [6:0] hr, logic [6:0] dy, logic [6:0] wd_);
        cur_time = {wd_, dy, hr, mi};
    endtask

    task automatic wr(logic [1:0] sel, logic d, logic [6:0] v);
        wr_en = 1; wr_sel = sel; wr_data = {d, v};
        tick();
        wr_en = 0;
    endtask

    task automatic clr();
        flag_clr = 1; tick(); flag_clr = 0;
    endtask

    initial begin
        // R1 reset state, R5 with everything disabled and time equal to stored zeros
        irq_en = 1;
        tick(3);
        rst_n = 1;
        tick(3);
        phase = "R5"; set_time(0, 0, 0, 0); tick(4);

        // R2 / R3: minute alarm at 0x30
        phase = "R2"; set_time(7'h29, 7'h11, 7'h05, 7'h2);
        wr(0, 0, 7'h30); tick(2);
        phase = "R3"; set_time(7'h30, 7'h11, 7'h05, 7'h2); tick(3);

        // R6 / R7: clear during a continuing match, flag stays low
        phase = "R7"; clr(); tick(4);
        phase = "R3"; set_time(7'h31, 7'h11, 7'h05, 7'h2); tick(2);
        set_time(7'h30, 7'h11, 7'h05, 7'h2); tick(2);
        phase = "R6"; set_time(7'h45, 7'h11, 7'h05, 7'h2); tick(3); clr(); tick(2);

        // R9: interrupt gating
        phase = "R9"; set_time(7'h30, 7'h11, 7'h05, 7'h2); tick(2);
        irq_en = 0; tick(2); irq_en = 1; tick(2); clr(); tick(2);

        // R4: hour enabled, weekday disabled with mismatching value
        phase = "R4"; wr(1, 0, 7'h12); wr(3, 1, 7'h5);
        set_time(7'h30, 7'h11, 7'h05, 7'h3); tick(3);
        set_time(7'h30, 7'h12, 7'h05, 7'h3); tick(3); clr(); tick(2);

        // R8: clear in same cycle as a fresh match
        phase = "R8"; set_time(7'h00, 7'h12, 7'h05, 7'h3); tick(2);
        cur_time[6:0] = 7'h30; flag_clr = 1; tick(); flag_clr = 0; tick(3); clr();

        // All fields enabled; one lane off by one at a time
        phase = "R4"; wr(2, 0, 7'h15); wr(3, 0, 7'h6);
        set_time(7'h30, 7'h12, 7'h15, 7'h5); tick(3);
        set_time(7'h30, 7'h12, 7'h14, 7'h6); tick(3);
        set_time(7'h30, 7'h13, 7'h15, 7'h6); tick(3);
        set_time(7'h31, 7'h12, 7'h15, 7'h6); tick(3);
        phase = "R3"; set_time(7'h30, 7'h12, 7'h15, 7'h6); tick(3); clr(); tick(2);

        // R5: disable everything, time equals stored values
        phase = "R5"; wr(0, 1, 7'h30); wr(1, 1, 7'h12); wr(2, 1, 7'h15); wr(3, 1, 7'h6);
        tick(5);

        // R10 / mixed random walk over a small alphabet
        phase = "R10";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            for (int f = 0; f < 4; f++) cur_time[f*7 +: 7] = 7'($urandom_range(0, 2));
            wr_en = (r == 0);
            wr_sel = 2'($urandom_range(0, 3));
            wr_data = {1'($urandom_range(0, 3) == 0), 7'($urandom_range(0, 2))};
            flag_clr = (r == 1 || r == 2);
            irq_en = (r != 3);
            tick();
        end
        wr_en = 0; flag_clr = 0;
        tick(2);
        @(posedge clk); #12;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule